// File: doc/BRIEF.md
# DDR2 Column-Command Data-Window Scheduler

This block sits between the column-command issue logic of a DDR2 memory controller and its data path. Each cycle it may be offered one read or write column command aimed at one of four banks. It keeps an open/closed flag per bank, driven by open and close inputs. It decides in the same cycle whether the command is accepted or dropped. A command is dropped if it comes too soon after the previous column command, if its bank is closed, or if it would put write data on the bus while read data is still there. For every accepted command it raises a per-cycle data-window enable at the exact cycle the data moves: `rd_valid` for read capture, `wr_drive` for write drive. Next to the enable it gives the index of the first data beat carried in that cycle.

Read latency is the additive latency plus the CAS latency. Write latency is one cycle shorter. Data moves on both clock edges, so a burst of 4 beats fills 2 cycles and a burst of 8 beats fills 4. The block takes the latency and burst settings from its configuration inputs only while it is idle, and holds them until all scheduled windows have finished. Two commands spaced exactly one burst apart chain with no idle cycle, whether they hit the same bank or different banks.

A data-bus state machine has four states. ST_IDLE means nothing is scheduled. ST_WAIT means windows are scheduled but the bus is quiet this cycle. ST_RD and ST_WR mean a read window or a write window occupies this cycle. All transitions are decided from the next-cycle view of the two latency pipelines. The state moves to ST_WR when a write beat is due, otherwise to ST_RD when a read beat is due, otherwise to ST_WAIT while anything is pending, and otherwise back to ST_IDLE. These give the transitions ST_IDLE→ST_WAIT on an accept, ST_WAIT→ST_RD/ST_WR at the latency, ST_RD↔ST_WR on a turnaround, ST_RD/ST_WR→ST_WAIT in a gap, and any state→ST_IDLE when drained.

Top module: `ddr2_burst_window_sched`

## Requirements
- R1: A read accepted in cycle c raises `rd_valid` in cycles c+RL to c+RL+N-1. RL = AL+CL, with AL from `cfg_al` (0..4) and CL from `cfg_cl` (3..6). N = 2 when `cfg_bl8`=0 (burst of 4) and N = 4 when `cfg_bl8`=1 (burst of 8).
- R2: A write accepted in cycle c raises `wr_drive` in cycles c+RL-1 to c+RL+N-2.
- R3: In the k-th cycle of a window (k counted from 0), `beat_idx` equals 2k, so it runs 0,2 for a burst of 4 and 0,2,4,6 for a burst of 8. Outside any window it is 0.
- R4: Column commands spaced exactly N cycles apart are all accepted, and their windows of the same direction join with no idle cycle, for the same bank or for different banks.
- R5: A command arriving fewer than N cycles after the last accepted command gives a one-cycle `col_drop_spacing` pulse in its own cycle and schedules no window.
- R6: A command to a closed bank gives `col_drop_bank` and is dropped. `bank_open_valid` opens bank `bank_open_id` and `bank_close_valid` closes bank `bank_close_id` from the next cycle on. If both name the same bank, close wins. A command in the same cycle is judged on the flags from before that cycle's open or close.
- R7: A write arriving exactly N cycles after an accepted read would overlap that read's last data cycle. It gives `col_drop_turn` and is dropped. `rd_valid` and `wr_drive` are never high together.
- R8: The checks are applied in a fixed priority: spacing first, then bank, then turnaround. When `col_valid` is high, exactly one of `col_accept`, `col_drop_spacing`, `col_drop_bank` and `col_drop_turn` is high. When `col_valid` is low, all four are low.
- R9: A synchronous reset (`rst` high at a clock edge) clears all bank flags and all scheduled windows. From the next cycle the enables and `beat_idx` are 0, and a command to any bank is dropped with `col_drop_bank`.
- R10: The configuration inputs take effect only in a cycle in which nothing is scheduled and no window is active. In any other cycle the values captured at the last such cycle are used for latency, burst length and spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_al | input | 3 | Additive latency, 0..4 |
| cfg_cl | input | 3 | CAS latency, 3..6 |
| cfg_bl8 | input | 1 | 1: burst of 8 beats, 0: burst of 4 beats |
| bank_open_valid | input | 1 | Open the bank named by bank_open_id |
| bank_open_id | input | 2 | Bank to open |
| bank_close_valid | input | 1 | Close the bank named by bank_close_id |
| bank_close_id | input | 2 | Bank to close |
| col_valid | input | 1 | A column command is offered this cycle |
| col_write | input | 1 | 1: write, 0: read |
| col_bank | input | 2 | Target bank of the column command |
| col_accept | output | 1 | Command accepted and scheduled |
| col_drop_spacing | output | 1 | Command dropped: too soon after the previous one |
| col_drop_bank | output | 1 | Command dropped: bank closed |
| col_drop_turn | output | 1 | Command dropped: write would collide with read data |
| rd_valid | output | 1 | Read data-capture window enable for this cycle |
| wr_drive | output | 1 | Write data-drive window enable for this cycle |
| beat_idx | output | 3 | First beat index carried in this cycle |

## Verification
A wrong bank flag or a wrong spacing counter shows at once as a wrong accept or drop output in the very cycle of the next command. A latency-pipeline or beat-counter fault shows as an enable or beat index off by a cycle at most RL+N cycles after the command that scheduled it. A stale or early-captured configuration shows as a window of the wrong length or offset on the first command after the change. The reference model predicts the accept/drop outputs, both enables and the beat index, and compares them in every cycle, so each of these faults is reported within one burst of the point where it becomes visible.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;
    localparam int NUM_BANKS = 4;
    localparam int AL_MAX    = 4;
    localparam int CL_MIN    = 3;
    localparam int CL_MAX    = 6;
    localparam int CFG_W     = 3;
    localparam int LAT_MAX   = AL_MAX + CL_MAX;
    localparam int LAT_W     = $clog2(LAT_MAX + 1);
    localparam int GAP_W     = 3;
    localparam int POS_W     = 2;
    localparam int BEAT_W    = POS_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR
    } bus_state_e;
endpackage

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker #(
    parameter int NB = ddr2_sched_pkg::NUM_BANKS,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_valid,
    input  logic [BW-1:0] open_id,
    input  logic          close_valid,
    input  logic [BW-1:0] close_id,
    output logic [NB-1:0] active
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [BW-1:0] ID = BW'(b);
        always_ff @(posedge clk) begin
            if (rst) begin
                active[b] <= 1'b0;
            end else if (close_valid && close_id == ID) begin
                active[b] <= 1'b0;
            end else if (open_valid && open_id == ID) begin
                active[b] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr2_col_gate.sv
module ddr2_col_gate #(
    parameter int NB   = ddr2_sched_pkg::NUM_BANKS,
    parameter int GW   = ddr2_sched_pkg::GAP_W,
    localparam int BW  = $clog2(NB),
    localparam logic [GW-1:0] GAP_SAT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          col_valid,
    input  logic          col_write,
    input  logic [BW-1:0] col_bank,
    input  logic [NB-1:0] bank_active,
    input  logic [GW-1:0] burst_clks,
    output logic          accept,
    output logic          drop_spacing,
    output logic          drop_bank,
    output logic          drop_turn
);
    logic [GW-1:0] gap_q;
    logic          last_rd_q;
    logic          too_soon;
    logic          collide;

    always_comb begin
        too_soon     = gap_q < burst_clks;
        collide      = col_write && last_rd_q && (gap_q == burst_clks);
        accept       = 1'b0;
        drop_spacing = 1'b0;
        drop_bank    = 1'b0;
        drop_turn    = 1'b0;
        if (col_valid) begin
            if (too_soon) begin
                drop_spacing = 1'b1;
            end else if (!bank_active[col_bank]) begin
                drop_bank = 1'b1;
            end else if (collide) begin
                drop_turn = 1'b1;
            end else begin
                accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= GAP_SAT;
            last_rd_q <= 1'b0;
        end else if (accept) begin
            gap_q     <= GW'(1);
            last_rd_q <= !col_write;
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $countones({accept, drop_spacing, drop_bank, drop_turn}) == (col_valid ? 1 : 0)); // R8
    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R5
    AST_BANK_OPEN: assert property (@(posedge clk) disable iff (rst)
        accept |-> bank_active[col_bank]); // R6
endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe #(
    parameter int LMAX = ddr2_sched_pkg::LAT_MAX,
    parameter int LW   = ddr2_sched_pkg::LAT_W,
    parameter int PW   = ddr2_sched_pkg::POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] lat,
    input  logic [PW-1:0] last_pos,
    output logic          win_q,
    output logic          win_d,
    output logic [PW-1:0] pos_d,
    output logic          busy_d
);
    logic [LMAX-1:0] sr_q, sr_d;
    logic [PW-1:0]   cnt_q, cnt_d;

    always_comb begin
        sr_d = sr_q >> 1;
        if (load) begin
            sr_d[lat - LW'(1)] = 1'b1;
        end
        if (sr_q[0]) begin
            cnt_d = last_pos;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - PW'(1);
        end else begin
            cnt_d = '0;
        end
        win_q  = sr_q[0] || (cnt_q != '0);
        win_d  = sr_d[0] || (cnt_d != '0);
        pos_d  = sr_d[0] ? '0 : PW'(last_pos - cnt_d + PW'(1));
        busy_d = (|sr_d) || (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_d;
            cnt_q <= cnt_d;
        end
    end

    AST_NO_SELF_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        sr_q[0] |-> (cnt_q == '0)); // R4
    AST_WINDOW_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!win_q && win_d) |-> (pos_d == '0)); // R3
endmodule

// File: rtl/ddr2_burst_window_sched.sv
module ddr2_burst_window_sched
    import ddr2_sched_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    localparam int BW = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_al,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic              cfg_bl8,
    input  logic              bank_open_valid,
    input  logic [BW-1:0]     bank_open_id,
    input  logic              bank_close_valid,
    input  logic [BW-1:0]     bank_close_id,
    input  logic              col_valid,
    input  logic              col_write,
    input  logic [BW-1:0]     col_bank,
    output logic              col_accept,
    output logic              col_drop_spacing,
    output logic              col_drop_bank,
    output logic              col_drop_turn,
    output logic              rd_valid,
    output logic              wr_drive,
    output logic [BEAT_W-1:0] beat_idx
);
    bus_state_e state_q, state_d;

    logic [CFG_W-1:0] al_h, cl_h, al_e, cl_e, al_c, cl_c;
    logic             bl8_h, bl8_e;
    logic [LAT_W-1:0] rl;
    logic [GAP_W-1:0] burst_clks;
    logic [POS_W-1:0] last_pos;
    logic [NB-1:0]    bank_active;
    logic [1:0]       win_q_a, win_d_a, busy_d_a;
    logic [POS_W-1:0] pos_d_a [2];
    logic [BEAT_W-1:0] beat_q;

    // configuration: live while idle, held otherwise
    always_comb begin
        if (state_q == ST_IDLE) begin
            al_e  = cfg_al;
            cl_e  = cfg_cl;
            bl8_e = cfg_bl8;
        end else begin
            al_e  = al_h;
            cl_e  = cl_h;
            bl8_e = bl8_h;
        end
        al_c = (al_e > CFG_W'(AL_MAX)) ? CFG_W'(AL_MAX) : al_e;
        if (cl_e < CFG_W'(CL_MIN)) begin
            cl_c = CFG_W'(CL_MIN);
        end else if (cl_e > CFG_W'(CL_MAX)) begin
            cl_c = CFG_W'(CL_MAX);
        end else begin
            cl_c = cl_e;
        end
        rl         = LAT_W'(al_c) + LAT_W'(cl_c);
        burst_clks = bl8_e ? GAP_W'(4) : GAP_W'(2);
        last_pos   = bl8_e ? POS_W'(3) : POS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            al_h  <= '0;
            cl_h  <= CFG_W'(CL_MIN);
            bl8_h <= 1'b0;
        end else begin
            al_h  <= al_e;
            cl_h  <= cl_e;
            bl8_h <= bl8_e;
        end
    end

    ddr2_bank_tracker #(.NB(NB)) u_banks (
        .clk         (clk),
        .rst         (rst),
        .open_valid  (bank_open_valid),
        .open_id     (bank_open_id),
        .close_valid (bank_close_valid),
        .close_id    (bank_close_id),
        .active      (bank_active)
    );

    ddr2_col_gate #(.NB(NB), .GW(GAP_W)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .col_valid    (col_valid),
        .col_write    (col_write),
        .col_bank     (col_bank),
        .bank_active  (bank_active),
        .burst_clks   (burst_clks),
        .accept       (col_accept),
        .drop_spacing (col_drop_spacing),
        .drop_bank    (col_drop_bank),
        .drop_turn    (col_drop_turn)
    );

    // index 0: read pipeline (RL), index 1: write pipeline (RL-1)
    for (genvar g = 0; g < 2; g++) begin : g_dir
        localparam logic IS_WR = (g == 1);
        logic             load;
        logic [LAT_W-1:0] lat;
        assign load = col_accept && (col_write == IS_WR);
        assign lat  = IS_WR ? (rl - LAT_W'(1)) : rl;
        ddr2_lat_pipe #(.LMAX(LAT_MAX), .LW(LAT_W), .PW(POS_W)) u_pipe (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .lat      (lat),
            .last_pos (last_pos),
            .win_q    (win_q_a[g]),
            .win_d    (win_d_a[g]),
            .pos_d    (pos_d_a[g]),
            .busy_d   (busy_d_a[g])
        );
    end

    // next-state decision
    always_comb begin
        if (win_d_a[1]) begin
            state_d = ST_WR;
        end else if (win_d_a[0]) begin
            state_d = ST_RD;
        end else if (|busy_d_a) begin
            state_d = ST_WAIT;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // state register and beat index register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (win_d_a[1]) begin
                beat_q <= {pos_d_a[1], 1'b0};
            end else if (win_d_a[0]) begin
                beat_q <= {pos_d_a[0], 1'b0};
            end else begin
                beat_q <= '0;
            end
        end
    end

    // outputs from state
    always_comb begin
        rd_valid = 1'b0;
        wr_drive = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: ;
            ST_RD:   rd_valid = 1'b1;
            ST_WR:   wr_drive = 1'b1;
        endcase
        beat_idx = beat_q;
    end

    AST_NO_BUS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(win_q_a[0] && win_q_a[1])); // R7
    AST_READ_STATE_MATCHES_PIPE: assert property (@(posedge clk) disable iff (rst)
        rd_valid == win_q_a[0]); // R1
    AST_WRITE_STATE_MATCHES_PIPE: assert property (@(posedge clk) disable iff (rst)
        wr_drive == win_q_a[1]); // R2
endmodule

// File: tb/tb_ddr2_burst_window_sched.sv
module tb_ddr2_burst_window_sched;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_al = 3'd2, cfg_cl = 3'd3;
    logic       cfg_bl8 = 1'b0;
    logic       bank_open_valid = 1'b0, bank_close_valid = 1'b0;
    logic [1:0] bank_open_id = '0, bank_close_id = '0;
    logic       col_valid = 1'b0, col_write = 1'b0;
    logic [1:0] col_bank = '0;
    logic       col_accept, col_drop_spacing, col_drop_bank, col_drop_turn;
    logic       rd_valid, wr_drive;
    logic [2:0] beat_idx;

    ddr2_burst_window_sched dut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, wd = 0;
    bit done = 0;
    string phase = "R9 reset";
    int n_al = 2, n_cl = 3; bit n_bl8 = 0;
    bit o_v = 0, c_v = 0; int o_b = 0, c_b = 0;

    // reference model state
    bit m_bank [4];
    int m_last = -1000, m_end = -1000;
    bit m_last_rd = 0;
    int h_al = 0, h_cl = 3; bit h_bl8 = 0;
    int ek [int];
    int ep [int];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, cyc, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
        m_last = -1000; m_end = -1000; m_last_rd = 0;
        ek.delete(); ep.delete();
    endtask

    task automatic step(input bit v, input bit w, input int b);
        int n, rl, lat, gap, e_rd, e_wr, e_bt;
        bit a, ds, db, dt;
        @(posedge clk); #1;
        cfg_al = 3'(n_al); cfg_cl = 3'(n_cl); cfg_bl8 = n_bl8;
        col_valid = v; col_write = w; col_bank = 2'(b);
        bank_open_valid = o_v; bank_open_id = 2'(o_b);
        bank_close_valid = c_v; bank_close_id = 2'(c_b);
        #3;
        if (rst) begin
            model_clear();
        end else begin
            if (m_end < cyc) begin h_al = n_al; h_cl = n_cl; h_bl8 = n_bl8; end
            n = h_bl8 ? 4 : 2;
            rl = h_al + h_cl;
            a = 0; ds = 0; db = 0; dt = 0;
            gap = cyc - m_last;
            if (v) begin
                if (gap < n) ds = 1;
                else if (!m_bank[b]) db = 1;
                else if (w && m_last_rd && gap == n) dt = 1;
                else a = 1;
            end
            chk(col_accept == a, "R8 accept", col_accept, a);
            chk(col_drop_spacing == ds, "R5 spacing drop", col_drop_spacing, ds);
            chk(col_drop_bank == db, "R6 bank drop", col_drop_bank, db);
            chk(col_drop_turn == dt, "R7 turnaround drop", col_drop_turn, dt);
            if (a) begin
                lat = w ? rl - 1 : rl;
                for (int k = 0; k < n; k++) begin
                    ek[cyc + lat + k] = w ? 2 : 1;
                    ep[cyc + lat + k] = 2 * k;
                end
                if (cyc + lat + n - 1 > m_end) m_end = cyc + lat + n - 1;
                m_last = cyc; m_last_rd = !w;
            end
            e_rd = (ek.exists(cyc) && ek[cyc] == 1) ? 1 : 0;
            e_wr = (ek.exists(cyc) && ek[cyc] == 2) ? 1 : 0;
            e_bt = ep.exists(cyc) ? ep[cyc] : 0;
            chk(rd_valid == e_rd, "R1 rd_valid", rd_valid, e_rd);
            chk(wr_drive == e_wr, "R2 wr_drive", wr_drive, e_wr);
            chk(int'(beat_idx) == e_bt, "R3 beat_idx", beat_idx, e_bt);
            chk(!(rd_valid && wr_drive), "R7 bus overlap", rd_valid & wr_drive, 0);
            if (o_v) m_bank[o_b] = 1;
            if (c_v) m_bank[c_b] = 0;
        end
        o_v = 0; c_v = 0;
        cyc++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0);
    endtask

    task automatic open_bank(input int b);
        o_v = 1; o_b = b; step(0, 0, 0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle(2);
        rst = 0;
        // R9: outputs zero, every bank closed after reset
        phase = "R9 after reset";
        step(1, 0, 0);
        idle(2);
        open_bank(0); open_bank(1); open_bank(2);
        // R1 R4 R5 R7 with burst of 4, RL=5
        phase = "R4 seamless bl4";
        step(1, 0, 0); idle(1);
        step(1, 0, 1);            // seamless, different bank
        step(1, 0, 1);            // gap 1: R5
        step(1, 1, 2);            // write exactly N after read: R7
        step(1, 1, 2);            // gap 3: accepted
        idle(1);
        step(1, 1, 2);            // seamless writes, same bank
        idle(1);
        step(1, 0, 1);            // write to read at N: accepted
        idle(15);
        phase = "R6 closed bank";
        step(1, 1, 3);
        idle(2);
        // R10: burst of 8, RL=6
        phase = "R10 bl8";
        n_al = 0; n_cl = 6; n_bl8 = 1;
        idle(1);
        step(1, 0, 0); idle(3);
        step(1, 1, 1);            // R7 at gap N
        step(1, 1, 1); idle(3);
        step(1, 0, 2);            // write to read at gap N
        step(1, 0, 2);            // R5 gap 1
        idle(1);
        n_al = 4; n_cl = 4; n_bl8 = 0;   // changed while busy: R10
        idle(1);
        step(1, 0, 0);            // uses held burst of 8, RL=6
        idle(20);
        phase = "R10 new cfg";
        step(1, 0, 0); idle(1);
        step(1, 0, 1);
        idle(20);
        // R6 open/close ordering
        phase = "R6 open close";
        c_v = 1; c_b = 1; o_v = 1; o_b = 1; step(0, 0, 0);
        step(1, 0, 1);            // close won: dropped
        idle(2);
        c_v = 1; c_b = 0; step(1, 0, 0);  // same-cycle close: old flag, accepted
        idle(1);
        step(1, 0, 0);            // now closed
        idle(15);
        // minimum latency RL=3, burst of 4
        phase = "R2 min latency";
        n_al = 0; n_cl = 3; n_bl8 = 0;
        idle(1);
        open_bank(0);
        step(1, 1, 0); idle(1);
        step(1, 0, 0); idle(1);
        step(1, 1, 0);            // R7
        step(1, 1, 0);
        idle(10);
        // R9 reset with windows pending
        phase = "R9 reset mid burst";
        step(1, 0, 2); idle(1);
        rst = 1; idle(2); rst = 0;
        idle(2);
        step(1, 0, 2);            // bank flags cleared
        idle(10);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule